// File: doc/BRIEF.md
# Two-Level Overriding Branch Predictor

This block is the branch prediction front end of a processor. Every cycle, a fast predictor looks up the fetch address in a direct-mapped branch target table. It uses the stored branch kind, the stored target, a 2-bit direction counter and a four-deep return stack to choose the next fetch address. One stage later, a slower predictor sees the decoded branch descriptor. That descriptor carries direct targets from the instruction bytes and indirect targets already read from a register or memory operand. The slower predictor works out its own next address. When that address differs from the one the fast predictor chose for the same block, the slower predictor wins. It raises a one-cycle flush of the fetched but not yet decoded instructions and steers fetch to its own address. Speculative issue therefore follows the decode-stage path.

The execute stage sends resolution updates. These updates are the only writes to the target table. A resolution marked as a misprediction redirects fetch to the corrected address, flushes the younger work and winds the return stack pointer back to the checkpoint carried with the branch. The return stack itself is pushed by decoded calls and popped by decoded returns. The fast predictor only peeks at the top entry. All outputs are registered and appear on the clock edge after the inputs that cause them.

Top module: `ovr_bpred`

## Requirements
- R1: While reset is high and on the edge that ends it, nxt_vld, dec_redirect and ovr_flush are 0, nxt_pc equals RESET_PC (default 0), and ras_ck is 0.
- R2: With only fetch_vld high and no target table hit, nxt_pc on the next edge is fetch_pc + 16 with nxt_vld high and both flush outputs low.
- R3: On a target table hit, the fetch prediction depends on the stored kind, encoded 0 conditional, 1 jump, 2 call, 3 return and 4 indirect. A conditional predicts the stored target when counter bit 1 is set and fetch_pc + 16 otherwise. A jump, call or indirect predicts the stored target.
- R4: The target table has 64 entries indexed by pc[9:4] and tagged by pc[31:10], and only ex_vld writes it. A missing taken branch is allocated with counter 2. A hit moves the counter one step toward the outcome, saturating at 0 and 3, and takes ex_tgt when taken. A missing not-taken branch leaves the table unchanged.
- R5: A decoded call (dec_kind 2) pushes dec_pc + 16 and a decoded return (dec_kind 3) pops. A fetch hit of kind return predicts the current top entry without popping it. ras_ck is {count[4:2], write pointer[1:0]}.
- R6: The stack holds 4 entries. A fifth push overwrites the oldest entry and leaves the count at 4. A return with the stack empty predicts fetch or decode pc + 16 and leaves ras_ck unchanged.
- R7: The decode target is dec_pc + 16 when dec_br is low. For a conditional it is dec_tgt when dec_tgt < dec_pc (unsigned) and dec_pc + 16 otherwise. For a jump, call or indirect it is dec_tgt. For a return it is the popped stack entry.
- R8: When dec_vld is high and the decode target differs from dec_fpred, the next edge gives dec_redirect = 1, ovr_flush = 1 and nxt_pc = decode target. When the two are equal, the fetch prediction proceeds with no flush.
- R9: ex_vld with ex_mis takes priority over decode and fetch. The next edge gives nxt_pc = ex_tgt when ex_taken and ex_pc + 16 otherwise, with ovr_flush = 1 and dec_redirect = 0. Any same-cycle decode stack operation is dropped.
- R10: On ex_vld with ex_mis, ras_ck takes the value of ex_ck on the next edge.
- R11: With fetch_vld, dec_vld and ex_vld all low, the next edge gives nxt_vld = 0 and both flush outputs 0, and nxt_pc holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | Fetch address valid this cycle |
| fetch_pc | input | AW | Current fetch block address |
| dec_vld | input | 1 | Decode descriptor valid |
| dec_br | input | 1 | Decoded block ends in a branch |
| dec_kind | input | 3 | Decoded branch kind |
| dec_pc | input | AW | Address of the decoded block |
| dec_tgt | input | AW | Decoded direct or operand-resolved target |
| dec_fpred | input | AW | Next address that fetch chose for this block |
| ex_vld | input | 1 | Execute resolution valid |
| ex_kind | input | 3 | Resolved branch kind |
| ex_pc | input | AW | Resolved branch block address |
| ex_taken | input | 1 | Resolved direction |
| ex_tgt | input | AW | Resolved target |
| ex_mis | input | 1 | Resolution was mispredicted |
| ex_ck | input | 5 | Stack checkpoint carried with the branch |
| nxt_vld | output | 1 | nxt_pc updated this cycle |
| nxt_pc | output | AW | Next fetch address |
| dec_redirect | output | 1 | Decode overrode the fetch prediction |
| ovr_flush | output | 1 | Flush fetched, undecoded instructions |
| ras_ck | output | 5 | Current stack checkpoint {count, pointer} |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. This holds for the fetch pick, the decode override, the execute redirect and the stack checkpoint, and a table write becomes visible to a lookup presented after that edge. The bench drives inputs just after the falling edge. Its reference model evaluates them at the rising edge, so it reads table and stack contents as they stood before that edge's writes. The design outputs are then compared at the following falling edge. Each comparison is labelled with the requirement that decided the expected value, for example the override rule, the execute priority or the stack wrap.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [2:0] {
    BK_COND = 3'd0,
    BK_JMP  = 3'd1,
    BK_CALL = 3'd2,
    BK_RET  = 3'd3,
    BK_IND  = 3'd4
  } br_kind_e;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic tk);
    logic [1:0] r;
    if (tk) r = (c == 2'b11) ? c : c + 2'b01;
    else    r = (c == 2'b00) ? c : c - 2'b01;
    return r;
  endfunction

endpackage

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int AW        = 32,
  parameter int ENT       = 64,
  parameter int BLK_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] lk_pc,
  output logic          lk_hit,
  output logic [2:0]    lk_kind,
  output logic [AW-1:0] lk_tgt,
  output logic [1:0]    lk_ctr,
  input  logic          up_vld,
  input  logic [AW-1:0] up_pc,
  input  logic [2:0]    up_kind,
  input  logic          up_taken,
  input  logic [AW-1:0] up_tgt
);
  import bp_pkg::*;

  localparam int OFS_W = $clog2(BLK_BYTES);
  localparam int IDX_W = $clog2(ENT);
  localparam int TAG_W = AW - IDX_W - OFS_W;

  logic [ENT-1:0]   vld_q;
  logic [TAG_W-1:0] tag_mem  [ENT];
  logic [AW-1:0]    tgt_mem  [ENT];
  logic [2:0]       kind_mem [ENT];
  logic [1:0]       ctr_mem  [ENT];

  logic [IDX_W-1:0] l_idx, u_idx;
  logic [TAG_W-1:0] l_tag, u_tag;
  logic             u_hit, u_wr;
  logic [1:0]       u_ctr;

  assign l_idx = lk_pc[OFS_W +: IDX_W];
  assign l_tag = lk_pc[AW-1 -: TAG_W];
  assign u_idx = up_pc[OFS_W +: IDX_W];
  assign u_tag = up_pc[AW-1 -: TAG_W];

  // lookup port: read before any same-edge write
  assign lk_hit  = vld_q[l_idx] && (tag_mem[l_idx] == l_tag);
  assign lk_kind = kind_mem[l_idx];
  assign lk_tgt  = tgt_mem[l_idx];
  assign lk_ctr  = ctr_mem[l_idx];

  // update port
  always_comb begin
    u_hit = vld_q[u_idx] && (tag_mem[u_idx] == u_tag);
    u_wr  = up_vld && !rst && (u_hit || up_taken);
    u_ctr = u_hit ? ctr_step(ctr_mem[u_idx], up_taken) : 2'b10;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (u_wr) vld_q[u_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (u_wr) begin
      tag_mem[u_idx]  <= u_tag;
      kind_mem[u_idx] <= up_kind;
      ctr_mem[u_idx]  <= u_ctr;
      if (up_taken) tgt_mem[u_idx] <= up_tgt;
    end
  end

  logic unused_ofs;
  assign unused_ofs = ^{lk_pc[OFS_W-1:0], up_pc[OFS_W-1:0]};

endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
  parameter int AW  = 32,
  parameter int DEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_val,
  input  logic          pop,
  input  logic          restore,
  input  logic [$clog2(DEP+1)+$clog2(DEP)-1:0] rs_ck,
  output logic [AW-1:0] top,
  output logic          nonempty,
  output logic [$clog2(DEP+1)+$clog2(DEP)-1:0] ck
);
  localparam int RPW  = $clog2(DEP);
  localparam int CNTW = $clog2(DEP + 1);
  localparam logic [RPW-1:0]  P_ONE = RPW'(1);
  localparam logic [CNTW-1:0] C_ONE = CNTW'(1);
  localparam logic [CNTW-1:0] FULL  = CNTW'(DEP);

  logic [AW-1:0]   mem [DEP];
  logic [RPW-1:0]  ptr_q;
  logic [CNTW-1:0] cnt_q;

  assign nonempty = (cnt_q != '0);
  assign top      = mem[ptr_q - P_ONE];
  assign ck       = {cnt_q, ptr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (restore) begin
      {cnt_q, ptr_q} <= rs_ck;
    end else if (push) begin
      ptr_q <= ptr_q + P_ONE;
      if (cnt_q != FULL) cnt_q <= cnt_q + C_ONE;
    end else if (pop && nonempty) begin
      ptr_q <= ptr_q - P_ONE;
      cnt_q <= cnt_q - C_ONE;
    end
  end

  // storage: circular, a push on a full stack overwrites the oldest slot
  always_ff @(posedge clk) begin
    if (!rst && !restore && push) mem[ptr_q] <= push_val;
  end

endmodule

// File: rtl/bp_dec_pred.sv
module bp_dec_pred #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 16
) (
  input  logic          br,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] tgt,
  input  logic [AW-1:0] ras_top,
  input  logic          ras_ne,
  output logic [AW-1:0] npc,
  output logic          is_call,
  output logic          is_ret
);
  import bp_pkg::*;

  localparam logic [AW-1:0] SEQ = AW'(BLK_BYTES);

  logic [AW-1:0] seq;
  assign seq = pc + SEQ;

  always_comb begin
    npc     = seq;
    is_call = 1'b0;
    is_ret  = 1'b0;
    if (br) begin
      unique case (kind)
        BK_COND: npc = (tgt < pc) ? tgt : seq;
        BK_CALL: begin
          npc     = tgt;
          is_call = 1'b1;
        end
        BK_RET: begin
          npc    = ras_ne ? ras_top : seq;
          is_ret = 1'b1;
        end
        BK_JMP, BK_IND: npc = tgt;
        default: npc = seq;
      endcase
    end
  end

endmodule

// File: rtl/ovr_bpred.sv
module ovr_bpred #(
  parameter int            AW        = 32,
  parameter int            BTB_ENT   = 64,
  parameter int            RAS_ENT   = 4,
  parameter int            BLK_BYTES = 16,
  parameter logic [AW-1:0] RESET_PC  = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_pc,
  input  logic          dec_vld,
  input  logic          dec_br,
  input  logic [2:0]    dec_kind,
  input  logic [AW-1:0] dec_pc,
  input  logic [AW-1:0] dec_tgt,
  input  logic [AW-1:0] dec_fpred,
  input  logic          ex_vld,
  input  logic [2:0]    ex_kind,
  input  logic [AW-1:0] ex_pc,
  input  logic          ex_taken,
  input  logic [AW-1:0] ex_tgt,
  input  logic          ex_mis,
  input  logic [$clog2(RAS_ENT+1)+$clog2(RAS_ENT)-1:0] ex_ck,
  output logic          nxt_vld,
  output logic [AW-1:0] nxt_pc,
  output logic          dec_redirect,
  output logic          ovr_flush,
  output logic [$clog2(RAS_ENT+1)+$clog2(RAS_ENT)-1:0] ras_ck
);
  import bp_pkg::*;

  localparam logic [AW-1:0] SEQ = AW'(BLK_BYTES);

  // fetch-stage lookup
  logic          f_hit;
  logic [2:0]    f_kind;
  logic [AW-1:0] f_tgt, f_npc, f_seq;
  logic [1:0]    f_ctr;
  logic [AW-1:0] r_top;
  logic          r_ne;

  bp_btb #(.AW(AW), .ENT(BTB_ENT), .BLK_BYTES(BLK_BYTES)) u_btb (
    .clk(clk), .rst(rst),
    .lk_pc(fetch_pc), .lk_hit(f_hit), .lk_kind(f_kind), .lk_tgt(f_tgt), .lk_ctr(f_ctr),
    .up_vld(ex_vld), .up_pc(ex_pc), .up_kind(ex_kind), .up_taken(ex_taken), .up_tgt(ex_tgt)
  );

  assign f_seq = fetch_pc + SEQ;

  always_comb begin
    f_npc = f_seq;
    if (f_hit) begin
      unique case (f_kind)
        BK_COND:               f_npc = f_ctr[1] ? f_tgt : f_seq;
        BK_RET:                f_npc = r_ne ? r_top : f_seq;
        BK_JMP, BK_CALL, BK_IND: f_npc = f_tgt;
        default:               f_npc = f_seq;
      endcase
    end
  end

  // decode-stage predictor
  logic [AW-1:0] d_npc;
  logic          d_call, d_ret;
  logic          ex_m, d_act, d_ovr;

  bp_dec_pred #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_dec (
    .br(dec_br), .kind(dec_kind), .pc(dec_pc), .tgt(dec_tgt),
    .ras_top(r_top), .ras_ne(r_ne),
    .npc(d_npc), .is_call(d_call), .is_ret(d_ret)
  );

  assign ex_m  = ex_vld && ex_mis;
  assign d_act = dec_vld && !ex_m;
  assign d_ovr = d_act && (d_npc != dec_fpred);

  bp_ras #(.AW(AW), .DEP(RAS_ENT)) u_ras (
    .clk(clk), .rst(rst),
    .push(d_act && d_call), .push_val(dec_pc + SEQ),
    .pop(d_act && d_ret),
    .restore(ex_m), .rs_ck(ex_ck),
    .top(r_top), .nonempty(r_ne), .ck(ras_ck)
  );

  // registered next-fetch selection: execute > decode > fetch
  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_vld      <= 1'b0;
      nxt_pc       <= RESET_PC;
      dec_redirect <= 1'b0;
      ovr_flush    <= 1'b0;
    end else begin
      nxt_vld      <= ex_m || d_ovr || fetch_vld;
      dec_redirect <= d_ovr;
      ovr_flush    <= ex_m || d_ovr;
      if (ex_m)           nxt_pc <= ex_taken ? ex_tgt : ex_pc + SEQ;
      else if (d_ovr)     nxt_pc <= d_npc;
      else if (fetch_vld) nxt_pc <= f_npc;
    end
  end

endmodule

// File: rtl/ovr_bpred_chk.sv
module ovr_bpred_chk #(
  parameter int AW      = 32,
  parameter int RAS_ENT = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          dec_vld,
  input logic [AW-1:0] dec_fpred,
  input logic          ex_vld,
  input logic          ex_mis,
  input logic          ex_taken,
  input logic [AW-1:0] ex_tgt,
  input logic [$clog2(RAS_ENT+1)+$clog2(RAS_ENT)-1:0] ex_ck,
  input logic          nxt_vld,
  input logic [AW-1:0] nxt_pc,
  input logic          dec_redirect,
  input logic          ovr_flush,
  input logic [$clog2(RAS_ENT+1)+$clog2(RAS_ENT)-1:0] ras_ck
);
  localparam int RPW  = $clog2(RAS_ENT);
  localparam int CNTW = $clog2(RAS_ENT + 1);
  localparam int CKW  = CNTW + RPW;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!nxt_vld && !ovr_flush && !dec_redirect && ras_ck == '0)); // R1

  AST_REDIR_FLUSHES: assert property (@(posedge clk) disable iff (rst)
    dec_redirect |-> ovr_flush); // R8

  AST_REDIR_DIFFERS: assert property (@(posedge clk) disable iff (rst)
    dec_redirect |-> (nxt_pc != $past(dec_fpred))); // R8

  AST_EX_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (ex_vld && ex_mis) |=> (nxt_vld && ovr_flush && !dec_redirect)); // R9

  AST_EX_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ex_vld && ex_mis && ex_taken) |=> (nxt_pc == $past(ex_tgt))); // R9

  AST_CK_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (ex_vld && ex_mis) |=> (ras_ck == $past(ex_ck))); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (!(ex_vld && ex_mis)) |=> (ras_ck[CKW-1:RPW] <= CNTW'(RAS_ENT))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!dec_vld && !ex_vld) |=> (!ovr_flush && !dec_redirect)); // R11

  AST_PC_STABLE: assert property (@(posedge clk) disable iff (rst)
    !nxt_vld |-> $stable(nxt_pc)); // R11

endmodule

bind ovr_bpred ovr_bpred_chk #(.AW(AW), .RAS_ENT(RAS_ENT)) u_chk (
  .clk(clk), .rst(rst), .dec_vld(dec_vld), .dec_fpred(dec_fpred),
  .ex_vld(ex_vld), .ex_mis(ex_mis), .ex_taken(ex_taken), .ex_tgt(ex_tgt), .ex_ck(ex_ck),
  .nxt_vld(nxt_vld), .nxt_pc(nxt_pc), .dec_redirect(dec_redirect),
  .ovr_flush(ovr_flush), .ras_ck(ras_ck)
);

// File: tb/ovr_bpred_tb.sv
module ovr_bpred_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_vld = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        dec_vld = 1'b0, dec_br = 1'b0;
  logic [2:0]  dec_kind = '0;
  logic [31:0] dec_pc = '0, dec_tgt = '0, dec_fpred = '0;
  logic        ex_vld = 1'b0, ex_taken = 1'b0, ex_mis = 1'b0;
  logic [2:0]  ex_kind = '0;
  logic [31:0] ex_pc = '0, ex_tgt = '0;
  logic [4:0]  ex_ck = '0;
  logic        nxt_vld, dec_redirect, ovr_flush;
  logic [31:0] nxt_pc;
  logic [4:0]  ras_ck;

  always #5 clk = ~clk;

  ovr_bpred u_dut (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
    .dec_vld(dec_vld), .dec_br(dec_br), .dec_kind(dec_kind), .dec_pc(dec_pc),
    .dec_tgt(dec_tgt), .dec_fpred(dec_fpred),
    .ex_vld(ex_vld), .ex_kind(ex_kind), .ex_pc(ex_pc), .ex_taken(ex_taken),
    .ex_tgt(ex_tgt), .ex_mis(ex_mis), .ex_ck(ex_ck),
    .nxt_vld(nxt_vld), .nxt_pc(nxt_pc), .dec_redirect(dec_redirect),
    .ovr_flush(ovr_flush), .ras_ck(ras_ck)
  );

  int n_chk = 0, n_err = 0, pen = 0;
  bit done = 0, mdl_on = 0;

  // ---------------- reference model ----------------
  bit          t_v [64];
  logic [31:0] t_tag [64], t_tgt [64];
  int          t_kind [64], t_ctr [64];
  logic [31:0] stk [4];
  int          sp, sc;
  logic        e_vld, e_rd, e_fl;
  logic [31:0] e_pc;
  string       rq, rq_ck;
  int          fi, ui;
  bit          fh, uh, exm, dov;
  logic [31:0] fnp, dnp, topv;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) t_v[i] = 0;
      sp = 0; sc = 0;
      e_vld = 0; e_rd = 0; e_fl = 0; e_pc = '0;
      rq = "R1"; rq_ck = "R1"; mdl_on = 1;
    end else begin
      topv = stk[(sp + 3) % 4];
      exm  = ex_vld && ex_mis;
      // fetch pick (R2, R3, R5, R6)
      fi = int'((fetch_pc >> 4) & 32'h3f);
      fh = t_v[fi] && (t_tag[fi] == (fetch_pc >> 10));
      fnp = fetch_pc + 16;
      if (fh) begin
        case (t_kind[fi])
          0: if (t_ctr[fi] >= 2) fnp = t_tgt[fi];
          3: if (sc > 0) fnp = topv;
          default: fnp = t_tgt[fi];
        endcase
      end
      // decode pick (R7)
      dnp = dec_pc + 16;
      if (dec_br) begin
        case (dec_kind)
          3'd0: if (dec_tgt < dec_pc) dnp = dec_tgt;
          3'd3: if (sc > 0) dnp = topv;
          default: dnp = dec_tgt;
        endcase
      end
      dov = dec_vld && !exm && (dnp != dec_fpred);
      // outputs
      e_rd = dov; e_fl = exm || dov;
      if (exm) begin
        e_vld = 1; e_pc = ex_taken ? ex_tgt : ex_pc + 16; rq = "R9"; pen += 10;
      end else if (dov) begin
        e_vld = 1; e_pc = dnp;
        rq = (dec_br && dec_kind == 3'd3) ? ((sc == 0) ? "R8 R6" : "R8 R5") : "R8 R7";
      end else if (fetch_vld) begin
        e_vld = 1; e_pc = fnp;
        rq = !fh ? "R2" : (t_kind[fi] == 3) ? ((sc == 0) ? "R6" : "R5") : "R3 R4";
      end else begin
        e_vld = 0; rq = "R11";
      end
      // stack update (R5, R6, R10)
      rq_ck = "R5";
      if (exm) begin
        sc = int'(ex_ck[4:2]); sp = int'(ex_ck[1:0]); rq_ck = "R10";
      end else if (dec_vld && dec_br && dec_kind == 3'd2) begin
        if (sc == 4) rq_ck = "R6";
        stk[sp] = dec_pc + 16; sp = (sp + 1) % 4; if (sc < 4) sc++;
      end else if (dec_vld && dec_br && dec_kind == 3'd3) begin
        if (sc > 0) begin sp = (sp + 3) % 4; sc--; end else rq_ck = "R6";
      end
      // table update (R4)
      if (ex_vld) begin
        ui = int'((ex_pc >> 4) & 32'h3f);
        uh = t_v[ui] && (t_tag[ui] == (ex_pc >> 10));
        if (uh || ex_taken) begin
          t_ctr[ui] = !uh ? 2 : ex_taken ? ((t_ctr[ui] == 3) ? 3 : t_ctr[ui] + 1)
                                         : ((t_ctr[ui] == 0) ? 0 : t_ctr[ui] - 1);
          t_v[ui] = 1; t_tag[ui] = ex_pc >> 10; t_kind[ui] = int'(ex_kind);
          if (ex_taken) t_tgt[ui] = ex_tgt;
        end
      end
    end
  end

  task automatic chk(input string r, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", r, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mdl_on && !done) begin
      chk(rq, "nxt_vld", 32'(nxt_vld), 32'(e_vld));
      chk(rq, "nxt_pc", nxt_pc, e_pc);
      chk(rq, "dec_redirect", 32'(dec_redirect), 32'(e_rd));
      chk(rq, "ovr_flush", 32'(ovr_flush), 32'(e_fl));
      chk(rq_ck, "ras_ck", 32'(ras_ck), {27'd0, sc[2:0], sp[1:0]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic quiet();
    fetch_vld = 0; dec_vld = 0; ex_vld = 0; ex_mis = 0;
  endtask
  task automatic tick();
    @(negedge clk);
    #1;
    quiet();
  endtask
  task automatic fetch(input logic [31:0] pc);
    fetch_vld = 1; fetch_pc = pc;
  endtask
  task automatic dec(input logic br, input logic [2:0] k, input logic [31:0] pc,
                     input logic [31:0] tg, input logic [31:0] fp);
    dec_vld = 1; dec_br = br; dec_kind = k; dec_pc = pc; dec_tgt = tg; dec_fpred = fp;
  endtask
  task automatic exu(input logic [2:0] k, input logic [31:0] pc, input logic tk,
                     input logic [31:0] tg, input logic mis, input logic [4:0] ck);
    ex_vld = 1; ex_kind = k; ex_pc = pc; ex_taken = tk; ex_tgt = tg; ex_mis = mis; ex_ck = ck;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    // R11 idle
    tick(); tick();
    // R2 sequential on miss
    fetch(32'h1000); tick();
    fetch(32'h1010); tick();
    // R4 allocate conditional taken, R3 counter use
    exu(3'd0, 32'h1000, 1, 32'h2000, 0, 5'd0); tick();
    fetch(32'h1000); tick();
    fetch(32'h1400); tick();                  // aliasing index, tag miss
    exu(3'd0, 32'h1000, 0, 32'h0, 0, 5'd0); tick();
    fetch(32'h1000); tick();                  // counter 1 -> sequential
    exu(3'd0, 32'h1000, 0, 32'h0, 0, 5'd0); tick();
    exu(3'd0, 32'h1000, 1, 32'h2400, 0, 5'd0); tick();
    fetch(32'h1000); tick();                  // counter 1 again
    exu(3'd0, 32'h1000, 1, 32'h2400, 0, 5'd0); tick();
    fetch(32'h1000); tick();                  // counter 2 -> target 2400
    exu(3'd0, 32'h1b00, 0, 32'h9000, 0, 5'd0); tick();
    fetch(32'h1b00); tick();                  // not-taken miss left out
    exu(3'd1, 32'h3000, 1, 32'h4000, 0, 5'd0); tick();
    exu(3'd4, 32'h5000, 1, 32'h6000, 0, 5'd0); tick();
    exu(3'd3, 32'h7000, 1, 32'h1234, 0, 5'd0); tick();
    fetch(32'h3000); tick();
    fetch(32'h5000); tick();
    fetch(32'h7000); tick();                  // return with empty stack
    // R5 / R6 pushes beyond depth
    for (int i = 0; i < 5; i++) begin
      dec(1, 3'd2, 32'h8000 + 32'(i) * 32'h100, 32'hA000, 32'hA000); tick();
    end
    fetch(32'h7000); tick();                  // peek top
    for (int i = 0; i < 5; i++) begin
      dec(1, 3'd3, 32'h9000, 32'h0, 32'h0); tick();
    end
    // R7 / R8 decode overrides
    dec(1, 3'd0, 32'h4000, 32'h3f00, 32'h4010); tick();   // backward taken, differs
    dec(1, 3'd0, 32'h4000, 32'h5000, 32'h4010); tick();   // forward, matches
    dec(0, 3'd1, 32'h4100, 32'h0, 32'h4110); fetch(32'h3000); tick();
    dec(1, 3'd4, 32'h4200, 32'hbeef0, 32'h4210); fetch(32'h3000); tick();
    // R9 / R10 execute priority and checkpoint restore
    dec(1, 3'd2, 32'hc000, 32'hd000, 32'h0);
    exu(3'd0, 32'h1000, 0, 32'h0, 1, 5'b01011); fetch(32'h3000); tick();
    exu(3'd1, 32'h3000, 1, 32'h4800, 1, 5'b00000); tick();
    fetch(32'h3000); tick();
    // mixed traffic
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 1) == 1) fetch(32'h1000 + 32'($urandom_range(0, 15)) * 32'h10);
      if ($urandom_range(0, 2) == 0)
        dec($urandom_range(0, 3) != 0, 3'($urandom_range(0, 4)),
            32'h1000 + 32'($urandom_range(0, 15)) * 32'h10,
            32'h1000 + 32'($urandom_range(0, 31)) * 32'h10,
            32'h1000 + 32'($urandom_range(0, 31)) * 32'h10);
      if ($urandom_range(0, 2) == 0)
        exu(3'($urandom_range(0, 4)), 32'h1000 + 32'($urandom_range(0, 15)) * 32'h10,
            1'($urandom_range(0, 1)), 32'h1000 + 32'($urandom_range(0, 31)) * 32'h10,
            $urandom_range(0, 5) == 0,
            {3'($urandom_range(0, 4)), 2'($urandom_range(0, 3))});
      tick();
    end
    tick();
    done = 1;
    $display("mispredict penalty cycles counted: %0d", pen);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule